// File: doc/BRIEF.md
# Coprocessor Command Dispatcher

This block is the register-mapped front end of a floating-point coprocessor. A host writes 32-bit words over a simple memory-mapped bus into a command register and an operand register. Each 16-bit command word is decoded in the coprocessor's native bit layout: a memory-or-register source flag, a source format or source register index, a destination register index and a 7-bit operation code. Decoded operations go to an execution unit through a valid/ready handshake, and the execution unit reports the end of each operation with a one-cycle completion pulse.

One operation may execute while a second waits in a one-deep pending slot. The slot is freed only when its command is actually handed to the execution unit; completion of the running operation alone never frees it. Unsupported operation codes are refused and flagged, and a command written while the slot is still occupied is rejected and flagged. A response register reads back the state of the dispatcher.

Top module: `cp_cmd_dispatch`

## Requirements
- R1: A command word is decoded as: bit 14 set means a memory source; bits 12..10 are the source format (memory source) or source register (register source); bits 9..7 are the destination register; bits 6..0 are the operation code. These fields appear unchanged on the issue outputs.
- R2: Only operation codes 0x00, 0x04, 0x0E, 0x20, 0x22, 0x23 and 0x28 are accepted. A command with any other code, written while the slot has room, is never issued and sets the sticky unimplemented bit (response bit 4).
- R3: A memory-source command is not offered for issue until an operand write has arrived that no earlier memory-source issue has consumed; a register-source command is offered with no operand.
- R4: A write to the operand register (address 1) captures all 32 data bits in one cycle; the issued operand and the operand readback equal the last such write.
- R5: A command is offered for issue only while no operation executes, or in the cycle the executing operation signals completion; each accepted issue starts a new executing operation.
- R6: While an operation executes, one further command (address 0, bits 15..0) is accepted into the pending slot and held there.
- R7: A command written in the same cycle that the pending slot is handed to the execution unit, including a hand-over in the completion cycle, is accepted and not lost.
- R8: The pending slot stays occupied until its command is handed over; a completion pulse alone does not empty it.
- R9: A command written while the slot is occupied and not being handed over is discarded, leaving the slot unchanged, and sets the sticky protocol-error bit (response bit 5).
- R10: A read returns data one cycle after the request. Address 2 returns the status code in bits 1..0 (0 idle, 1 executing with empty slot, 2 slot occupied) plus bits 4 and 5; address 1 returns the operand; address 0 returns the pending command word, or 0 when the slot is empty; address 3 returns 0.
- R11: Synchronous reset clears the executing state, the pending slot, the operand flag and both sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | ADDR_W | Write address (0 command, 1 operand) |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | ADDR_W | Read address |
| bus_rdata | output | DATA_W | Registered read data |
| iss_valid | output | 1 | Decoded operation offered |
| iss_ready | input | 1 | Execution unit takes the operation |
| iss_op | output | 7 | Operation code |
| iss_mem | output | 1 | Memory-source flag |
| iss_src | output | 3 | Source format or source register |
| iss_dst | output | 3 | Destination register |
| iss_operand | output | DATA_W | Captured memory operand |
| exe_done | input | 1 | One-cycle completion pulse from the execution unit |

## Verification
A command or operand write lands in registers at the clock edge where it is sampled, so the offer on iss_valid and its fields may change from the very next cycle, and the effect of exe_done on iss_valid is combinational within its own cycle. Read data is due one edge after bus_rd and reflects the state before that edge. The bench drives every input just after the falling edge, compares the issue outputs a moment later against a cycle-stepped model of the requirements, and checks each read on the following falling edge against the expectation it stored when the read was requested.

// File: rtl/cp_cmd_pkg.sv
package cp_cmd_pkg;

  // Command word layout (fixed by the coprocessor protocol)
  localparam int CMD_W   = 16;
  localparam int OPC_W   = 7;
  localparam int IDX_W   = 3;
  localparam int MEM_BIT = 14;
  localparam int SRC_LSB = 10;
  localparam int DST_LSB = 7;

  // Bus register map
  localparam int A_CMD  = 0;
  localparam int A_OPND = 1;
  localparam int A_RESP = 2;

  // Response field positions
  localparam int UNIMP_BIT = 4;
  localparam int PERR_BIT  = 5;

  // Supported operation codes
  localparam int N_OPS = 7;
  localparam logic [OPC_W-1:0] OPC_LIST [N_OPS] = '{
    7'h00, 7'h04, 7'h0E, 7'h20, 7'h22, 7'h23, 7'h28
  };

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FULL = 2'd2
  } stat_e;

  typedef struct packed {
    logic             mem;
    logic [IDX_W-1:0] src;
    logic [IDX_W-1:0] dst;
    logic [OPC_W-1:0] op;
  } cmd_t;

  function automatic logic op_known(input logic [OPC_W-1:0] op);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N_OPS; i++) begin
      if (op == OPC_LIST[i]) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/cp_cmd_decode.sv
module cp_cmd_decode
  import cp_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_t             fields,
  output logic             known
);

  logic [N_OPS-1:0] hit;

  for (genvar g = 0; g < N_OPS; g++) begin : g_hit
    assign hit[g] = (word[OPC_W-1:0] == OPC_LIST[g]);
  end

  assign known      = |hit;
  assign fields.mem = word[MEM_BIT];
  assign fields.src = word[SRC_LSB +: IDX_W];
  assign fields.dst = word[DST_LSB +: IDX_W];
  assign fields.op  = word[OPC_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{word[CMD_W-1], word[MEM_BIT-1]};

endmodule

// File: rtl/cp_pend_slot.sv
module cp_pend_slot
  import cp_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  cmd_t              load_cmd,
  input  logic [CMD_W-1:0]  load_word,
  input  logic              take,
  input  logic              opnd_wr,
  input  logic [DATA_W-1:0] opnd_data,
  output logic              vld,
  output cmd_t              cmd,
  output logic [CMD_W-1:0]  word,
  output logic [DATA_W-1:0] opnd,
  output logic              fresh
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      cmd  <= '0;
      word <= '0;
    end else if (load) begin
      vld  <= 1'b1;
      cmd  <= load_cmd;
      word <= load_word;
    end else if (take) begin
      vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd  <= '0;
      fresh <= 1'b0;
    end else if (opnd_wr) begin
      opnd  <= opnd_data;
      fresh <= 1'b1;
    end else if (take && cmd.mem) begin
      fresh <= 1'b0;
    end
  end

endmodule

// File: rtl/cp_resp_reg.sv
module cp_resp_reg
  import cp_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] raddr,
  input  stat_e             code,
  input  logic              unimp,
  input  logic              perr,
  input  logic              slot_vld,
  input  logic [CMD_W-1:0]  word,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] rdata
);

  localparam int WPAD = DATA_W - CMD_W;

  logic [DATA_W-1:0] resp_w;
  logic [DATA_W-1:0] sel_w;

  always_comb begin
    resp_w            = '0;
    resp_w[1:0]       = code;
    resp_w[UNIMP_BIT] = unimp;
    resp_w[PERR_BIT]  = perr;
  end

  always_comb begin
    if (raddr == ADDR_W'(A_RESP))      sel_w = resp_w;
    else if (raddr == ADDR_W'(A_OPND)) sel_w = opnd;
    else if (raddr == ADDR_W'(A_CMD))  sel_w = {{WPAD{1'b0}}, (slot_vld ? word : '0)};
    else                               sel_w = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel_w;
  end

endmodule

// File: rtl/cp_cmd_dispatch.sv
module cp_cmd_dispatch
  import cp_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [OPC_W-1:0]  iss_op,
  output logic              iss_mem,
  output logic [IDX_W-1:0]  iss_src,
  output logic [IDX_W-1:0]  iss_dst,
  output logic [DATA_W-1:0] iss_operand,
  input  exe_done
);

  logic              cmd_wr, opnd_wr;
  cmd_t              dec_fields;
  logic              dec_known;
  logic              slot_vld, opnd_fresh;
  cmd_t              slot_cmd;
  logic [CMD_W-1:0]  slot_word;
  logic [DATA_W-1:0] slot_opnd;
  logic              handoff, room, load;
  logic              busy_q, unimp_q, perr_q;
  stat_e             code;

  assign cmd_wr  = bus_wr && (bus_waddr == ADDR_W'(A_CMD));
  assign opnd_wr = bus_wr && (bus_waddr == ADDR_W'(A_OPND));

  cp_cmd_decode u_dec (
    .word   (bus_wdata[CMD_W-1:0]),
    .fields (dec_fields),
    .known  (dec_known)
  );

  assign handoff = iss_valid && iss_ready;
  assign room    = !slot_vld || handoff;
  assign load    = cmd_wr && room && dec_known;

  cp_pend_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_cmd  (dec_fields),
    .load_word (bus_wdata[CMD_W-1:0]),
    .take      (handoff),
    .opnd_wr   (opnd_wr),
    .opnd_data (bus_wdata),
    .vld       (slot_vld),
    .cmd       (slot_cmd),
    .word      (slot_word),
    .opnd      (slot_opnd),
    .fresh     (opnd_fresh)
  );

  always_ff @(posedge clk) begin
    if (rst)            busy_q <= 1'b0;
    else if (handoff)   busy_q <= 1'b1;
    else if (exe_done)  busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unimp_q <= 1'b0;
      perr_q  <= 1'b0;
    end else if (cmd_wr) begin
      if (!room)           perr_q  <= 1'b1;
      else if (!dec_known) unimp_q <= 1'b1;
    end
  end

  assign iss_valid   = slot_vld && (!slot_cmd.mem || opnd_fresh) && (!busy_q || exe_done);
  assign iss_op      = slot_cmd.op;
  assign iss_mem     = slot_cmd.mem;
  assign iss_src     = slot_cmd.src;
  assign iss_dst     = slot_cmd.dst;
  assign iss_operand = slot_opnd;

  always_comb begin
    if (slot_vld)    code = ST_FULL;
    else if (busy_q) code = ST_BUSY;
    else             code = ST_IDLE;
  end

  cp_resp_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_resp (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .raddr    (bus_raddr),
    .code     (code),
    .unimp    (unimp_q),
    .perr     (perr_q),
    .slot_vld (slot_vld),
    .word     (slot_word),
    .opnd     (slot_opnd),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/cp_cmd_dispatch_chk.sv
module cp_cmd_dispatch_chk
  import cp_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             iss_mem,
  input logic [OPC_W-1:0] iss_op,
  input logic             exe_done,
  input logic             busy,
  input logic             slot_vld,
  input logic             opnd_fresh,
  input logic             perr
);

  AST_ISSUE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (!busy || exe_done)); // R5

  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready) |=> busy); // R5

  AST_KNOWN_OP_ONLY: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> op_known(iss_op)); // R2

  AST_MEM_HAS_OPND: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_mem) |-> opnd_fresh); // R3

  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (rst)
    (slot_vld && !(iss_valid && iss_ready)) |=> slot_vld); // R8

  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_op))); // R6

  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    perr |=> perr); // R9

endmodule

bind cp_cmd_dispatch cp_cmd_dispatch_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_mem    (iss_mem),
  .iss_op     (iss_op),
  .exe_done   (exe_done),
  .busy       (busy_q),
  .slot_vld   (slot_vld),
  .opnd_fresh (opnd_fresh),
  .perr       (perr_q)
);

// File: tb/cp_cmd_dispatch_tb_top.sv
`timescale 1ns/1ps
module cp_cmd_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [6:0]  iss_op;
  logic        iss_mem;
  logic [2:0]  iss_src, iss_dst;
  logic [31:0] iss_operand;
  logic        exe_done = 1'b0;

  always #4 clk = ~clk;

  cp_cmd_dispatch dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_mem(iss_mem), .iss_src(iss_src), .iss_dst(iss_dst),
    .iss_operand(iss_operand), .exe_done(exe_done)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Requirement model
  bit          m_busy, m_vld, m_fresh, m_unimp, m_perr;
  logic [15:0] m_word;
  logic [31:0] m_opnd;
  bit          rd_pend;
  logic [31:0] rd_exp;
  string       rd_tag;
  bit          last_hs;

  function automatic bit known(input logic [6:0] op);
    return op inside {7'h00, 7'h04, 7'h0E, 7'h20, 7'h22, 7'h23, 7'h28};
  endfunction

  function automatic logic [31:0] resp_word();
    logic [1:0] code;
    code = m_vld ? 2'd2 : (m_busy ? 2'd1 : 2'd0);
    return {26'd0, m_perr, m_unimp, 2'b00, code};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit w, input logic [1:0] wa, input logic [31:0] wd,
                      input bit rdy, input bit dn, input bit rd, input logic [1:0] ra,
                      input string tag);
    bit exp_v, hs, room;
    @(negedge clk);
    if (rd_pend) chk(bus_rdata === rd_exp, rd_tag, bus_rdata, rd_exp);
    rd_pend = 0;
    rst = r; bus_wr = w; bus_waddr = wa; bus_wdata = wd;
    iss_ready = rdy; exe_done = dn; bus_rd = rd; bus_raddr = ra;
    #1;
    last_hs = 0;
    if (r) begin
      m_busy = 0; m_vld = 0; m_fresh = 0; m_unimp = 0; m_perr = 0;
      m_word = '0; m_opnd = '0;
    end else begin
      exp_v = m_vld && (!m_word[14] || m_fresh) && (!m_busy || dn);
      chk(iss_valid === exp_v, {tag, " R3 R5 offer"}, 32'(iss_valid), 32'(exp_v));
      if (exp_v) begin
        chk({iss_mem, iss_src, iss_dst, iss_op} === {m_word[14], m_word[12:10], m_word[9:7], m_word[6:0]},
            {tag, " R1 fields"}, {18'd0, iss_mem, iss_src, iss_dst, iss_op},
            {18'd0, m_word[14], m_word[12:10], m_word[9:7], m_word[6:0]});
        if (m_word[14]) chk(iss_operand === m_opnd, {tag, " R4 operand"}, iss_operand, m_opnd);
      end
      if (rd) begin
        rd_pend = 1;
        rd_tag  = {tag, " R10 read"};
        case (ra)
          2'd2:    rd_exp = resp_word();
          2'd1:    rd_exp = m_opnd;
          2'd0:    rd_exp = {16'd0, m_vld ? m_word : 16'd0};
          default: rd_exp = '0;
        endcase
      end
      hs = exp_v && rdy;
      last_hs = hs;
      room = !m_vld || hs;
      if (hs && m_word[14]) m_fresh = 0;
      if (hs) m_busy = 1; else if (dn) m_busy = 0;
      if (hs) m_vld = 0;
      if (w && wa == 2'd1) begin m_opnd = wd; m_fresh = 1; end
      if (w && wa == 2'd0) begin
        if (!room) m_perr = 1;
        else if (!known(wd[6:0])) m_unimp = 1;
        else begin m_vld = 1; m_word = wd[15:0]; end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    int unsigned s;
    s = $urandom(32'd1234);
    step(1,0,0,0,0,0,0,0,"reset");
    step(1,0,0,0,0,0,0,0,"reset");
    step(0,0,0,0,0,0,1,2,"R11 reset response");
    step(0,1,0,32'h00A2,0,0,0,0,"R1 reg add");
    step(0,0,0,0,1,0,1,2,"R10 pending code");
    step(0,1,0,32'h4022,1,0,1,2,"R6 busy code");
    step(0,0,0,0,1,0,1,2,"R6 held while busy");
    step(0,1,1,32'h12345678,1,0,0,0,"R3 operand arrives");
    step(0,0,0,0,0,1,1,2,"R8 completion keeps slot");
    step(0,1,0,32'h0023,0,0,0,0,"R9 reject");
    step(0,0,0,0,0,0,1,0,"R9 slot intact");
    step(0,0,0,0,0,0,1,2,"R9 sticky error");
    step(0,1,0,32'h44A2,1,0,1,1,"R7 write during handoff");
    step(0,0,0,0,0,0,1,0,"R7 accepted");
    step(0,1,1,32'h3F800000,0,0,1,1,"R4 operand write");
    step(0,1,0,32'h0005,1,1,0,0,"R2 unsupported in done cycle");
    step(0,0,0,0,1,1,1,2,"R2 unimp status");
    step(0,0,0,0,1,0,1,0,"R2 never issued");
    step(0,0,0,0,0,0,1,3,"R10 unmapped");
    step(1,0,0,0,0,0,0,0,"R11 reset");
    step(0,0,0,0,1,1,1,2,"R11 cleared");
    step(0,0,0,0,1,0,0,0,"R11 idle");
    cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      bit w, dn, rdy;
      logic [1:0] wa;
      logic [31:0] wd;
      logic [6:0] op;
      dn = 0;
      if (m_busy) begin
        if (cnt == 0) dn = 1; else cnt--;
      end
      w  = ($urandom % 100) < 35;
      wa = 2'($urandom % 2);
      if (wa == 2'd0) begin
        case ($urandom % 9)
          0: op = 7'h00; 1: op = 7'h04; 2: op = 7'h0E; 3: op = 7'h20;
          4: op = 7'h22; 5: op = 7'h23; 6: op = 7'h28; 7: op = 7'h05;
          default: op = 7'h3A;
        endcase
        wd = {16'd0, 1'b0, 1'($urandom), 1'b0, 3'($urandom), 3'($urandom), op};
      end else begin
        wd = $urandom;
      end
      rdy = ($urandom % 10) < 7;
      step(0, w, wa, wd, rdy, dn, ($urandom % 2) == 0, 2'($urandom % 4), "random");
      if (last_hs) cnt = $urandom % 4;
    end
    step(0,0,0,0,0,0,0,0,"drain");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule